// File: doc/BRIEF.md
# Indexed Register Window for an Interrupt Routing Controller

This block is the software-facing register front end of an I/O interrupt routing controller. A bus master sees only two locations. One is an index register, and the other is a data window. A read or write of the window reaches whichever internal register the index currently names. The internal registers are a version word, an identification word, an arbitration word, and one 64-bit routing entry per interrupt input. Each routing entry is split across two consecutive index values, one for each 32-bit half.

The delivery logic that sits beside the block uses a side port. On this port it can view any routing entry, mark an entry as in service (the remote IRR flag) and present the live request level of each input. When software rewrites a routing entry while that input is requesting, the block emits a one-cycle service pulse that names the pin. The delivery logic can then re-evaluate that pin. Interrupt delivery itself is not part of this block.

The routing entry fields used here are as follows: vector [7:0], delivery mode [10:8], destination mode [11], delivery status [12], polarity [13], remote IRR [14], trigger mode [15], mask [16] and destination [63:56].

Top module: `ioregwin_top`

## Requirements
- R1: Only `bus_addr[7:0]` is decoded. Offset 0x00 is the index register, which stores write data bits 7:0 and reads back zero-extended. Offset 0x10 is the data window. Reads of any other offset return zero, and writes to them change nothing. `bus_rdata` is combinational in the same cycle as `bus_re` and is zero while `bus_re` is low.
- R2: Index 0x01 reads as NUM_PINS-1 in bits 23:16 and the version code (default 0x11) in bits 7:0, with all other bits zero. Window writes to it are ignored.
- R3: Indices 0x00 and 0x02 both read the 4-bit controller ID in bits 27:24. A window write at index 0x00 loads the ID from data bits 27:24. A write at index 0x02 leaves the ID unchanged.
- R4: An index of 0x10 or above selects routing entry (index-0x10)>>1. An even index reaches entry bits 31:0 and an odd index reaches bits 63:32.
- R5: Window writes to an entry number at or above NUM_PINS (24) are dropped, and reads of such entries return zero. Indices 0x03 to 0x0F read zero.
- R6: A pulse on `rirr_set[p]` sets entry bit 14 of pin p. A write to the low half of an entry always stores 0 in bit 14, and this wins over a simultaneous set. A write to the high half leaves bit 14 unchanged.
- R7: A request is sampled as `pin_req` registered once. If that sampled request of pin p was high at the edge that writes either half of entry p, `svc_valid` is high for the next cycle with `svc_pin` = p. Otherwise `svc_valid` stays low.
- R8: `bus_size` encodes 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes. Writes of size 0 or 1 are ignored. A size 3 write uses only `bus_wdata[31:0]`.
- R9: After synchronous reset, the index, the ID, the sampled requests and `svc_valid` are zero, and every entry equals 0x0000_0000_0001_0000 (mask set).
- R10: `view_entry` shows the full 64-bit entry of `view_pin` in the same cycle, or zero when `view_pin` is NUM_PINS or above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (12) | Bus byte address; low 8 bits decoded |
| bus_re | input | 1 | Read strobe |
| bus_we | input | 1 | Write strobe |
| bus_size | input | 2 | Access size code |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| pin_req | input | NUM_PINS | Live request level per input |
| rirr_set | input | NUM_PINS | Mark entry in service |
| view_pin | input | PIN_W (5) | Entry selected for viewing |
| view_entry | output | 64 | Viewed routing entry |
| svc_valid | output | 1 | Service request pulse |
| svc_pin | output | PIN_W (5) | Pin named by the service pulse |

## Verification
The window is exercised with a sweep that writes distinct low and high patterns into every entry. Each pattern carries the pin number, so an index-to-entry or half-select mistake shows up as a wrong word read back. Out-of-range indices, the read-only version and arbitration slots, and short writes are each followed by read-backs of neighbouring state, which separates a dropped write from a misrouted one. The remote IRR flag is driven from both sides, including a set in the same cycle as a low-half write. Service pulses are checked with the request both high and low, so that an unconditional pulse and a missing pulse can be told apart.

// File: rtl/ioregwin_pkg.sv
package ioregwin_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } acc_size_e;

    typedef enum logic [2:0] {
        WSEL_ID,
        WSEL_VER,
        WSEL_ARB,
        WSEL_ENT,
        WSEL_NONE
    } win_sel_e;

    typedef struct packed {
        logic       idx_we;
        logic       win_we;
        win_sel_e   sel;
        logic [7:0] ent;
        logic       hi;
    } acc_t;

    localparam logic [7:0] OFS_INDEX  = 8'h00;
    localparam logic [7:0] OFS_WINDOW = 8'h10;
    localparam logic [7:0] IX_ID      = 8'h00;
    localparam logic [7:0] IX_VER     = 8'h01;
    localparam logic [7:0] IX_ARB     = 8'h02;
    localparam logic [7:0] IX_ENT0    = 8'h10;
    localparam int         BIT_RIRR   = 14;
    localparam int         BIT_MASK   = 16;
    localparam logic [63:0] ENT_RESET = 64'(1) << BIT_MASK;

    function automatic logic [7:0] entry_of(logic [7:0] idx);
        return (idx - IX_ENT0) >> 1;
    endfunction

    function automatic win_sel_e classify(logic [7:0] idx, int pins);
        win_sel_e s;
        case (idx)
            IX_ID:   s = WSEL_ID;
            IX_VER:  s = WSEL_VER;
            IX_ARB:  s = WSEL_ARB;
            default: begin
                if (idx >= IX_ENT0 && int'(entry_of(idx)) < pins) s = WSEL_ENT;
                else                                               s = WSEL_NONE;
            end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/ioregwin_decode.sv
module ioregwin_decode
    import ioregwin_pkg::*;
#(
    parameter int NUM_PINS = 24
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] ofs,
    input  logic       we,
    input  logic [1:0] size,
    input  logic [7:0] idx,
    output acc_t       acc
);

    logic size_ok;

    always_comb begin
        size_ok    = (acc_size_e'(size) == SZ_WORD) || (acc_size_e'(size) == SZ_DWORD);
        acc        = '0;
        acc.sel    = classify(idx, NUM_PINS);
        acc.ent    = entry_of(idx);
        acc.hi     = idx[0];
        acc.idx_we = we && size_ok && (ofs == OFS_INDEX);
        acc.win_we = we && size_ok && (ofs == OFS_WINDOW);
    end

    // R8: short writes never produce a write strobe
    p_short_write_dropped_r8: assert property (@(posedge clk) disable iff (rst)
        (we && size[1] == 1'b0) |-> (!acc.idx_we && !acc.win_we));

    // R1: a write strobe only comes from the two decoded offsets
    p_strobe_offset_r1: assert property (@(posedge clk) disable iff (rst)
        (acc.idx_we || acc.win_we) |-> (ofs == OFS_INDEX || ofs == OFS_WINDOW));

endmodule

// File: rtl/ioregwin_ident.sv
module ioregwin_ident #(
    parameter int          NUM_PINS = 24,
    parameter logic [7:0]  VERSION  = 8'h11
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        id_we,
    input  logic [31:0] wdata,
    output logic [3:0]  id_q,
    output logic [31:0] ver_word
);

    localparam logic [7:0] MAX_PIN = 8'(NUM_PINS - 1);

    assign ver_word = {8'h00, MAX_PIN, 8'h00, VERSION};

    always_ff @(posedge clk) begin
        if (rst)        id_q <= 4'h0;
        else if (id_we) id_q <= wdata[27:24];
    end

    // R3: the ID only moves on a write at its own index
    p_id_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(id_we)) |-> (id_q == $past(id_q)));

endmodule

// File: rtl/ioregwin_table.sv
module ioregwin_table
    import ioregwin_pkg::*;
#(
    parameter int NUM_PINS = 24
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_PINS-1:0]        wr_lo,
    input  logic [NUM_PINS-1:0]        wr_hi,
    input  logic [31:0]                wdata,
    input  logic [NUM_PINS-1:0]        rirr_set,
    output logic [NUM_PINS-1:0][63:0]  ent_q
);

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_ent
        logic [63:0] nxt;

        always_comb begin
            nxt = ent_q[g];
            if (wr_hi[g]) nxt[63:32] = wdata;
            if (wr_lo[g]) begin
                nxt[31:0]     = wdata;
                nxt[BIT_RIRR] = 1'b0;
            end else if (rirr_set[g]) begin
                nxt[BIT_RIRR] = 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) ent_q[g] <= ENT_RESET;
            else     ent_q[g] <= nxt;
        end

        // R6: a low-half write leaves remote IRR clear
        p_lo_clears_rirr_r6: assert property (@(posedge clk) disable iff (rst)
            $past(wr_lo[g]) |-> !ent_q[g][BIT_RIRR]);

        // R6: a high-half write alone keeps remote IRR
        p_hi_keeps_rirr_r6: assert property (@(posedge clk) disable iff (rst)
            ($past(wr_hi[g]) && !$past(wr_lo[g]) && !$past(rirr_set[g]) && !$past(rst))
            |-> (ent_q[g][BIT_RIRR] == $past(ent_q[g][BIT_RIRR])));
    end

endmodule

// File: rtl/ioregwin_top.sv
module ioregwin_top
    import ioregwin_pkg::*;
#(
    parameter int         NUM_PINS = 24,
    parameter int         ADDR_W   = 12,
    parameter logic [7:0] VERSION  = 8'h11,
    localparam int        PIN_W    = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_re,
    input  logic                bus_we,
    input  logic [1:0]          bus_size,
    input  logic [63:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] pin_req,
    input  logic [NUM_PINS-1:0] rirr_set,
    input  logic [PIN_W-1:0]    view_pin,
    output logic [63:0]         view_entry,
    output logic                svc_valid,
    output logic [PIN_W-1:0]    svc_pin
);

    logic [7:0]                 ofs;
    logic [7:0]                 idx_q;
    logic [NUM_PINS-1:0]        req_q;
    logic [NUM_PINS-1:0]        wr_lo;
    logic [NUM_PINS-1:0]        wr_hi;
    logic [NUM_PINS-1:0][63:0]  ents;
    logic [31:0]                wdata;
    logic [3:0]                 id_q;
    logic [31:0]                ver_word;
    logic                       id_we;
    logic                       ent_wr;
    logic [PIN_W-1:0]           ent_pin;
    logic [31:0]                win_rd;
    acc_t                       acc;
    logic                       unused_bits;

    assign ofs         = bus_addr[7:0];
    assign wdata       = bus_wdata[31:0];
    assign unused_bits = ^{bus_addr[ADDR_W-1:8], bus_wdata[63:32]};

    ioregwin_decode #(.NUM_PINS(NUM_PINS)) u_decode (
        .clk  (clk),
        .rst  (rst),
        .ofs  (ofs),
        .we   (bus_we),
        .size (bus_size),
        .idx  (idx_q),
        .acc  (acc)
    );

    assign id_we   = acc.win_we && (acc.sel == WSEL_ID);
    assign ent_wr  = acc.win_we && (acc.sel == WSEL_ENT);
    assign ent_pin = acc.ent[PIN_W-1:0];

    always_comb begin
        for (int p = 0; p < NUM_PINS; p++) begin
            wr_lo[p] = ent_wr && (acc.ent == 8'(p)) && !acc.hi;
            wr_hi[p] = ent_wr && (acc.ent == 8'(p)) &&  acc.hi;
        end
    end

    ioregwin_ident #(.NUM_PINS(NUM_PINS), .VERSION(VERSION)) u_ident (
        .clk      (clk),
        .rst      (rst),
        .id_we    (id_we),
        .wdata    (wdata),
        .id_q     (id_q),
        .ver_word (ver_word)
    );

    ioregwin_table #(.NUM_PINS(NUM_PINS)) u_table (
        .clk      (clk),
        .rst      (rst),
        .wr_lo    (wr_lo),
        .wr_hi    (wr_hi),
        .wdata    (wdata),
        .rirr_set (rirr_set),
        .ent_q    (ents)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q     <= 8'h00;
            req_q     <= '0;
            svc_valid <= 1'b0;
            svc_pin   <= '0;
        end else begin
            if (acc.idx_we) idx_q <= wdata[7:0];
            req_q     <= pin_req;
            svc_valid <= ent_wr && req_q[ent_pin];
            svc_pin   <= ent_pin;
        end
    end

    always_comb begin
        case (acc.sel)
            WSEL_ID, WSEL_ARB: win_rd = {4'h0, id_q, 24'h0};
            WSEL_VER:          win_rd = ver_word;
            WSEL_ENT:          win_rd = acc.hi ? ents[ent_pin][63:32] : ents[ent_pin][31:0];
            default:           win_rd = 32'h0;
        endcase
        if (!bus_re)                 bus_rdata = 32'h0;
        else if (ofs == OFS_INDEX)   bus_rdata = {24'h0, idx_q};
        else if (ofs == OFS_WINDOW)  bus_rdata = win_rd;
        else                         bus_rdata = 32'h0;
    end

    assign view_entry = (int'(view_pin) < NUM_PINS) ? ents[view_pin] : 64'h0;

    // R7: a service pulse follows an entry write whose pin was requesting
    p_svc_after_write_r7: assert property (@(posedge clk) disable iff (rst)
        svc_valid |-> ($past(ent_wr) && $past(req_q[ent_pin])));

    // R7: a service pulse lasts one cycle unless writes continue
    p_svc_single_r7: assert property (@(posedge clk) disable iff (rst)
        (svc_valid && !$past(ent_wr, 1)) |-> 1'b0);

    // R1: undecoded offsets read zero
    p_other_ofs_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (bus_re && ofs != OFS_INDEX && ofs != OFS_WINDOW) |-> (bus_rdata == 32'h0));

    // R9: index is zero right after reset
    p_idx_after_reset_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (idx_q == 8'h00 && !svc_valid));

endmodule

// File: tb/tb_ioregwin_top.sv
module tb_ioregwin_top;

    localparam int NP    = 24;
    localparam int PIN_W = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [11:0]   bus_addr = '0;
    logic          bus_re = 1'b0;
    logic          bus_we = 1'b0;
    logic [1:0]    bus_size = 2'd2;
    logic [63:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_req = '0;
    logic [NP-1:0] rirr_set = '0;
    logic [PIN_W-1:0] view_pin = '0;
    logic [63:0]   view_entry;
    logic          svc_valid;
    logic [PIN_W-1:0] svc_pin;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    ioregwin_top dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_re(bus_re), .bus_we(bus_we),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_req(pin_req), .rirr_set(rirr_set), .view_pin(view_pin),
        .view_entry(view_entry), .svc_valid(svc_valid), .svc_pin(svc_pin)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [1:0] sz, logic [63:0] d);
        @(negedge clk);
        bus_addr = a; bus_size = sz; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        #1 d = bus_rdata;
        bus_re = 1'b0;
    endtask

    task automatic rd_idx(logic [7:0] ix, output logic [31:0] d);
        wr(12'h000, 2'd2, 64'(ix));
        rd(12'h010, d);
    endtask

    task automatic wr_idx(logic [7:0] ix, logic [31:0] d);
        wr(12'h000, 2'd2, 64'(ix));
        wr(12'h010, 2'd2, 64'(d));
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(12'h000, d);          chk("R9 index", 64'(d), 64'h0);
        rd_idx(8'h00, d);        chk("R9 id", 64'(d), 64'h0);
        chk("R9 svc", 64'(svc_valid), 64'h0);
        for (int p = 0; p < NP; p++) begin
            view_pin = PIN_W'(p); #1;
            chk("R9 entry", view_entry, 64'h0000_0000_0001_0000);
        end
    endtask

    task automatic t_offsets();
        logic [31:0] d;
        wr(12'h000, 2'd2, 64'h1234_5637);
        rd(12'h000, d);          chk("R1 index readback", 64'(d), 64'h37);
        rd(12'h100, d);          chk("R1 upper addr ignored", 64'(d), 64'h37);
        wr(12'h020, 2'd2, 64'h55);
        rd(12'h004, d);          chk("R1 other offset", 64'(d), 64'h0);
        rd(12'h000, d);          chk("R1 other write ignored", 64'(d), 64'h37);
        @(negedge clk); bus_addr = 12'h000; #1;
        chk("R1 no strobe zero", 64'(bus_rdata), 64'h0);
    endtask

    task automatic t_version();
        logic [31:0] d;
        wr_idx(8'h01, 32'hFFFF_FFFF);
        rd(12'h010, d);          chk("R2 version", 64'(d), 64'h0017_0011);
    endtask

    task automatic t_ident();
        logic [31:0] d;
        wr_idx(8'h00, 32'hA500_0000);
        rd(12'h010, d);          chk("R3 id idx0", 64'(d), 64'h0500_0000);
        rd_idx(8'h02, d);        chk("R3 id idx2", 64'(d), 64'h0500_0000);
        wr(12'h010, 2'd2, 64'h0C00_0000);
        rd_idx(8'h00, d);        chk("R3 arb write ignored", 64'(d), 64'h0500_0000);
    endtask

    function automatic logic [31:0] lo_pat(int p);
        return {8'(p), 8'hC7, 8'(p * 3 + 1), 8'h5A};
    endfunction

    function automatic logic [31:0] hi_pat(int p);
        return {8'(p + 8'h40), 24'h00BEEF ^ 24'(p)};
    endfunction

    task automatic t_sweep();
        logic [31:0] d;
        for (int p = 0; p < NP; p++) begin
            wr_idx(8'(16 + 2 * p), lo_pat(p));
            wr_idx(8'(17 + 2 * p), hi_pat(p));
        end
        for (int p = 0; p < NP; p++) begin
            rd_idx(8'(16 + 2 * p), d);
            chk("R4 low half", 64'(d), 64'(lo_pat(p) & 32'hFFFF_BFFF));
            rd_idx(8'(17 + 2 * p), d);
            chk("R4 high half", 64'(d), 64'(hi_pat(p)));
        end
        view_pin = 5'd23; #1;
        chk("R10 view", view_entry, {hi_pat(23), lo_pat(23) & 32'hFFFF_BFFF});
        view_pin = 5'd30; #1;
        chk("R10 view out of range", view_entry, 64'h0);
    endtask

    task automatic t_range();
        logic [31:0] d;
        wr_idx(8'h40, 32'hDEAD_BEEF);
        rd(12'h010, d);          chk("R5 oob read", 64'(d), 64'h0);
        wr_idx(8'hFF, 32'hDEAD_BEEF);
        view_pin = 5'd23; #1;
        chk("R5 entry 23 intact", view_entry, {hi_pat(23), lo_pat(23) & 32'hFFFF_BFFF});
        rd_idx(8'h05, d);        chk("R5 gap index", 64'(d), 64'h0);
    endtask

    task automatic t_rirr();
        logic [31:0] d;
        @(negedge clk); rirr_set[4] = 1'b1;
        @(negedge clk); rirr_set[4] = 1'b0;
        rd_idx(8'h18, d);        chk("R6 set", 64'(d[14]), 64'h1);
        wr_idx(8'h19, 32'h1111_2222);
        rd_idx(8'h18, d);        chk("R6 hi keeps", 64'(d[14]), 64'h1);
        wr_idx(8'h18, 32'h0000_0000);
        rd(12'h010, d);          chk("R6 lo clears", 64'(d), 64'h0);
        // set and low write in the same cycle: write wins
        wr(12'h000, 2'd2, 64'h18);
        @(negedge clk);
        bus_addr = 12'h010; bus_size = 2'd2; bus_wdata = 64'h0000_4001; bus_we = 1'b1;
        rirr_set[4] = 1'b1;
        @(negedge clk); bus_we = 1'b0; rirr_set[4] = 1'b0;
        rd(12'h010, d);          chk("R6 write wins", 64'(d), 64'h0000_0001);
    endtask

    task automatic t_service();
        @(negedge clk); pin_req[5] = 1'b1;
        wr(12'h000, 2'd2, 64'h1B);
        wr(12'h010, 2'd2, 64'h7);
        chk("R7 svc valid", 64'(svc_valid), 64'h1);
        chk("R7 svc pin", 64'(svc_pin), 64'h5);
        @(negedge clk);
        chk("R7 svc one cycle", 64'(svc_valid), 64'h0);
        pin_req[5] = 1'b0;
        @(negedge clk);
        wr(12'h010, 2'd2, 64'h8);
        chk("R7 no req no svc", 64'(svc_valid), 64'h0);
    endtask

    task automatic t_size();
        logic [31:0] d;
        wr(12'h000, 2'd2, 64'h20);
        wr(12'h000, 2'd0, 64'h30);
        wr(12'h000, 2'd1, 64'h31);
        rd(12'h000, d);          chk("R8 short writes ignored", 64'(d), 64'h20);
        wr(12'h010, 2'd3, 64'hFFFF_FFFF_0000_1234);
        rd(12'h010, d);          chk("R8 dword low bits", 64'(d), 64'h1234);
        rd_idx(8'h21, d);        chk("R8 high half untouched", 64'(d), 64'(hi_pat(8)));
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        t_reset();
        t_offsets();
        t_version();
        t_ident();
        t_sweep();
        t_range();
        t_rirr();
        t_service();
        t_size();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule